// File: doc/BRIEF.md
# Serial-Loaded Phase and Attenuation Control Register

This block is the control logic for a digitally stepped phase shifter and attenuator. A host shifts a 12-bit control word in, one bit at a time, on a serial data line qualified by a serial clock. It then pulses a latch strobe. The strobe copies the low eleven bits of the word into an operating register. This happens only when the first bit of the word, a change-enable flag, is set. The operating register drives eleven complementary line pairs: six set the phase state and five set the attenuation state.

The serial clock, the latch strobe and the data line are asynchronous to the system clock. Each one passes through a multi-stage synchronizer, and the serial clock and the strobe also pass through rising-edge detectors. The system clock must run at least four times faster than the serial clock. The synchronized serial clock and strobe are sent out again, together with the oldest stage of the shift chain. This lets several devices share one bit stream in a daisy chain. A device further down the chain receives the bits that this device pushes out.

Top module: `serial_phase_atten_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, every true control line is 0 and every complement line is 1 (zero added phase, zero added attenuation). The forwarded data output is also 0.
- R2: Each rising serial-clock edge shifts one data bit into the chain, so the most recent 12 bits form the word. The first bit of a 12-bit frame lands in position 11 (the change-enable flag) and the last bit lands in position 0. Bits sent before the last 12 have no effect.
- R3: A rising strobe edge with position 11 equal to 1 loads positions 10..0 into the operating register.
- R4: A rising strobe edge with position 11 equal to 0 leaves every control line unchanged.
- R5: Phase line i (i = 0..5) follows word position i. Position 5 is the smallest step (5.625 degrees) and position 0 is the largest (180 degrees).
- R6: Attenuation line k (k = 0..4) follows word position 6+k. Position 10 is the smallest step (0.7 dB) and position 6 is the largest (11.2 dB).
- R7: Every complement line is the exact inverse of its true line in every cycle.
- R8: The forwarded data output always shows word position 11, so each shift pushes the previous position 10 out to the next device.
- R9: The forwarded serial clock and strobe copy the inputs with a delay of two system clock cycles.
- R10: When a serial-clock edge and a strobe edge are detected in the same system cycle, the operating register takes the word as it stood before that shift.
- R11: A strobe rise on the input changes the control lines on the third rising system-clock edge after the input changes. No change appears earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| ser_ltc_i | input | 1 | Latch strobe; acts on its rising edge |
| ser_clk_o | output | 1 | Synchronized copy of the serial clock for the next device |
| ser_dat_o | output | 1 | Oldest shift stage (word position 11) |
| ser_ltc_o | output | 1 | Synchronized copy of the strobe for the next device |
| phase_ctl_o | output | 6 | Phase control lines, true polarity |
| phase_ctl_n_o | output | 6 | Phase control lines, complement |
| atten_ctl_o | output | 5 | Attenuation control lines, true polarity |
| atten_ctl_n_o | output | 5 | Attenuation control lines, complement |

## Verification
A shift and a latch can be detected in the same system cycle. In that case the load must use the word as it stood before the shift, not after. The bench provokes this by raising the serial clock and the strobe on the same system-clock edge right after a complete enabled frame. It judges the result by checking that the control lines show that frame, while the forwarded data output has advanced by one bit. A behavioural reference model, built from input history queues, is compared with every output on every cycle. It therefore also checks that the pre-shift word is used for every other overlap of a strobe edge with a clock edge.

// File: rtl/spa_pkg.sv
package spa_pkg;

   // Serial control lines carried together through the synchronizer
   typedef struct packed {
      logic clk_lvl;
      logic dat_lvl;
      logic ltc_lvl;
   } spa_lines_t;

   localparam int SPA_MIN_SYNC = 2;

endpackage

// File: rtl/spa_sync.sv
module spa_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stage [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("spa_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[0] <= '0;
               else        stage[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage[STAGES-1];

endmodule

// File: rtl/spa_shift_chain.sv
module spa_shift_chain #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o
);

   generate
      if (WIDTH < 2) begin : g_bad
         $error("spa_shift_chain: WIDTH must be at least 2");
      end
      for (genvar k = 0; k < WIDTH; k++) begin : g_cell
         logic nxt;
         if (k == 0) begin : g_head
            assign nxt = bit_i;
         end else begin : g_body
            assign nxt = word_o[k-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       word_o[k] <= 1'b0;
            else if (shift_i) word_o[k] <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/spa_oper_reg.sv
module spa_oper_reg #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             enable_i,
   input  logic [WIDTH-1:0] word_i,
   output logic [WIDTH-1:0] oper_o
);

   logic take;
   assign take = load_i & enable_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    oper_o <= '0;
      else if (take) oper_o <= word_i;
   end

endmodule

// File: rtl/spa_line_driver.sv
module spa_line_driver #(
   parameter int PHASE_BITS = 6,
   parameter int ATTEN_BITS = 5,
   localparam int OPER_BITS = PHASE_BITS + ATTEN_BITS
) (
   input  logic [OPER_BITS-1:0]  oper_i,
   output logic [PHASE_BITS-1:0] phase_o,
   output logic [PHASE_BITS-1:0] phase_n_o,
   output logic [ATTEN_BITS-1:0] atten_o,
   output logic [ATTEN_BITS-1:0] atten_n_o
);

   generate
      for (genvar i = 0; i < PHASE_BITS; i++) begin : g_ph
         assign phase_o[i]   = oper_i[i];
         assign phase_n_o[i] = ~oper_i[i];
      end
      for (genvar k = 0; k < ATTEN_BITS; k++) begin : g_at
         assign atten_o[k]   = oper_i[PHASE_BITS+k];
         assign atten_n_o[k] = ~oper_i[PHASE_BITS+k];
      end
   endgenerate

endmodule

// File: rtl/serial_phase_atten_ctl.sv
module serial_phase_atten_ctl
   import spa_pkg::*;
#(
   parameter int PHASE_BITS  = 6,
   parameter int ATTEN_BITS  = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_clk_i,
   input  logic                  ser_dat_i,
   input  logic                  ser_ltc_i,
   output logic                  ser_clk_o,
   output logic                  ser_dat_o,
   output logic                  ser_ltc_o,
   output logic [PHASE_BITS-1:0] phase_ctl_o,
   output logic [PHASE_BITS-1:0] phase_ctl_n_o,
   output logic [ATTEN_BITS-1:0] atten_ctl_o,
   output logic [ATTEN_BITS-1:0] atten_ctl_n_o
);

   localparam int OPER_BITS  = PHASE_BITS + ATTEN_BITS;
   localparam int FRAME_BITS = OPER_BITS + 1;
   localparam int LINE_BITS  = $bits(spa_lines_t);

   generate
      if (SYNC_STAGES < SPA_MIN_SYNC) begin : g_bad_sync
         $error("serial_phase_atten_ctl: SYNC_STAGES below minimum");
      end
      if (PHASE_BITS < 1 || ATTEN_BITS < 1) begin : g_bad_width
         $error("serial_phase_atten_ctl: field widths must be positive");
      end
   endgenerate

   spa_lines_t raw_lines;
   spa_lines_t sync_lines;
   logic       ci_prev;
   logic       le_prev;
   logic       ci_rise;
   logic       le_rise;
   logic [FRAME_BITS-1:0] shreg;
   logic [OPER_BITS-1:0]  oper;

   assign raw_lines.clk_lvl = ser_clk_i;
   assign raw_lines.dat_lvl = ser_dat_i;
   assign raw_lines.ltc_lvl = ser_ltc_i;

   spa_sync #(
      .WIDTH  (LINE_BITS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   // Rising-edge detection on the synchronized clock and strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ci_prev <= 1'b0;
         le_prev <= 1'b0;
      end else begin
         ci_prev <= sync_lines.clk_lvl;
         le_prev <= sync_lines.ltc_lvl;
      end
   end

   assign ci_rise = sync_lines.clk_lvl & ~ci_prev;
   assign le_rise = sync_lines.ltc_lvl & ~le_prev;

   spa_shift_chain #(
      .WIDTH (FRAME_BITS)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (ci_rise),
      .bit_i   (sync_lines.dat_lvl),
      .word_o  (shreg)
   );

   spa_oper_reg #(
      .WIDTH (OPER_BITS)
   ) u_oper (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (le_rise),
      .enable_i (shreg[FRAME_BITS-1]),
      .word_i   (shreg[OPER_BITS-1:0]),
      .oper_o   (oper)
   );

   spa_line_driver #(
      .PHASE_BITS (PHASE_BITS),
      .ATTEN_BITS (ATTEN_BITS)
   ) u_drv (
      .oper_i    (oper),
      .phase_o   (phase_ctl_o),
      .phase_n_o (phase_ctl_n_o),
      .atten_o   (atten_ctl_o),
      .atten_n_o (atten_ctl_n_o)
   );

   assign ser_dat_o = shreg[FRAME_BITS-1];
   assign ser_clk_o = sync_lines.clk_lvl;
   assign ser_ltc_o = sync_lines.ltc_lvl;

endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
   parameter int PHASE_BITS = 6,
   parameter int ATTEN_BITS = 5,
   localparam int OPER_BITS  = PHASE_BITS + ATTEN_BITS,
   localparam int FRAME_BITS = OPER_BITS + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ci_rise,
   input logic                  le_rise,
   input logic [FRAME_BITS-1:0] shreg,
   input logic                  ser_dat_o,
   input logic [PHASE_BITS-1:0] phase_ctl_o,
   input logic [PHASE_BITS-1:0] phase_ctl_n_o,
   input logic [ATTEN_BITS-1:0] atten_ctl_o,
   input logic [ATTEN_BITS-1:0] atten_ctl_n_o
);

   AST_NO_SHIFT_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !ci_rise |=> $stable(shreg)); // R2

   AST_ENABLED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && shreg[FRAME_BITS-1]) |=>
         ({atten_ctl_o, phase_ctl_o} == $past(shreg[OPER_BITS-1:0]))); // R3

   AST_BLOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && !shreg[FRAME_BITS-1]) |=> $stable({atten_ctl_o, phase_ctl_o})); // R4

   AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable({atten_ctl_o, phase_ctl_o})); // R3

   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_ctl_n_o == ~phase_ctl_o) && (atten_ctl_n_o == ~atten_ctl_o)); // R7

   AST_PUSH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ci_rise |=> (ser_dat_o == $past(shreg[FRAME_BITS-2]))); // R8

endmodule

bind serial_phase_atten_ctl spa_checker #(
   .PHASE_BITS (PHASE_BITS),
   .ATTEN_BITS (ATTEN_BITS)
) u_spa_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .ci_rise       (ci_rise),
   .le_rise       (le_rise),
   .shreg         (shreg),
   .ser_dat_o     (ser_dat_o),
   .phase_ctl_o   (phase_ctl_o),
   .phase_ctl_n_o (phase_ctl_n_o),
   .atten_ctl_o   (atten_ctl_o),
   .atten_ctl_n_o (atten_ctl_n_o)
);

// File: tb/serial_phase_atten_ctl_test.sv
`timescale 1ns/1ps
module serial_phase_atten_ctl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ci = 1'b0, di = 1'b0, le = 1'b0;
   logic co, dout, leo;
   logic [5:0] ph, ph_n;
   logic [4:0] at, at_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   serial_phase_atten_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(ci), .ser_dat_i(di), .ser_ltc_i(le),
      .ser_clk_o(co), .ser_dat_o(dout), .ser_ltc_o(leo),
      .phase_ctl_o(ph), .phase_ctl_n_o(ph_n),
      .atten_ctl_o(at), .atten_ctl_n_o(at_n)
   );

   // Behavioural reference: input history queues, word and held setting
   logic q_ci [4];
   logic q_di [4];
   logic q_le [4];
   logic [11:0] m_word;
   logic [10:0] m_hold;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            q_ci[i] = 0; q_di[i] = 0; q_le[i] = 0;
         end
         m_word = '0;
         m_hold = '0;
      end else begin
         logic c_edge, l_edge, nb;
         c_edge = q_ci[1] & ~q_ci[2];
         l_edge = q_le[1] & ~q_le[2];
         nb     = q_di[1];
         if (l_edge && m_word[11]) m_hold = m_word[10:0];
         if (c_edge) m_word = {m_word[10:0], nb};
         for (int i = 3; i > 0; i--) begin
            q_ci[i] = q_ci[i-1]; q_di[i] = q_di[i-1]; q_le[i] = q_le[i-1];
         end
         q_ci[0] = ci; q_di[0] = di; q_le[0] = le;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R11: every-cycle comparison against the reference model
   always @(negedge clk) begin
      if (rst_n && !done)
         check("R11 cycle model",
               {7'd0, ph, ph_n, at, at_n, dout, co, leo},
               {7'd0, m_hold[5:0], ~m_hold[5:0], m_hold[10:6], ~m_hold[10:6],
                m_word[11], q_ci[1], q_le[1]});
   end

   function automatic logic [11:0] mk(input logic en, input logic [4:0] a, input logic [5:0] p);
      return {en, a, p};
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk); di = b; ci = 1'b0;
      repeat (3) @(negedge clk);
      ci = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_frame(input logic [11:0] w);
      for (int i = 11; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic strobe();
      @(negedge clk); le = 1'b1;
      repeat (4) @(negedge clk);
      le = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic expect_word(input string req, input logic [11:0] w);
      check(req, {26'd0, ph}, {26'd0, w[5:0]});
      check(req, {27'd0, at}, {27'd0, w[10:6]});
      check({req, " complement"}, {21'd0, ph_n, at_n}, {21'd0, ~w[5:0], ~w[10:6]});
   endtask

   initial begin : watchdog
      #3_000_000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [11:0] fa, fb, fc, fd, fe, fones;
      repeat (3) @(negedge clk);
      // R1: during reset
      check("R1 reset lines", {10'd0, ph, ph_n, at, at_n}, {10'd0, 6'h00, 6'h3F, 5'h00, 5'h1F});
      check("R1 reset data out", {31'd0, dout}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {10'd0, ph, ph_n, at, at_n}, {10'd0, 6'h00, 6'h3F, 5'h00, 5'h1F});

      // R3 R5 R6 R7: enabled frame
      fa = mk(1'b1, 5'b10011, 6'b101101);
      send_frame(fa);
      strobe();
      expect_word("R3 R5 R6 enabled load", fa);

      // R4: disabled frame leaves lines alone
      fb = mk(1'b0, 5'b01100, 6'b010010);
      send_frame(fb);
      check("R8 oldest stage", {31'd0, dout}, {31'd0, fb[11]});
      strobe();
      expect_word("R4 blocked load", fa);

      // R8: bits leave toward the next device in order
      fc = mk(1'b1, 5'b00101, 6'b110001);
      send_bit(fc[11]);
      check("R8 pushed bit 1", {31'd0, dout}, {31'd0, fb[10]});
      send_bit(fc[10]);
      check("R8 pushed bit 2", {31'd0, dout}, {31'd0, fb[9]});
      for (int i = 9; i >= 0; i--) send_bit(fc[i]);
      check("R8 new oldest", {31'd0, dout}, {31'd0, fc[11]});

      // R2: extra leading bits are discarded
      fd = mk(1'b1, 5'b11010, 6'b000111);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      send_frame(fd);
      strobe();
      expect_word("R2 last twelve bits", fd);

      // R5 R6: all-ones and all-zeros boundaries
      fones = mk(1'b1, 5'h1F, 6'h3F);
      send_frame(fones);
      strobe();
      expect_word("R5 R6 all ones", fones);
      send_frame(mk(1'b1, 5'h00, 6'h00));
      strobe();
      expect_word("R5 R6 all zeros", 12'h800);

      // R9 R10 R11: shift and strobe edges together after an enabled frame
      fe = mk(1'b1, 5'b01001, 6'b100110);
      send_frame(fe);
      @(negedge clk); ci = 1'b0;
      repeat (4) @(negedge clk);
      di = 1'b1; ci = 1'b1; le = 1'b1;
      @(negedge clk);
      check("R9 clock copy early", {31'd0, co}, 32'd0);
      check("R9 strobe copy early", {31'd0, leo}, 32'd0);
      @(negedge clk);
      check("R9 clock copy", {31'd0, co}, 32'd1);
      check("R9 strobe copy", {31'd0, leo}, 32'd1);
      expect_word("R11 not yet", 12'h800);
      @(negedge clk);
      expect_word("R10 pre-shift word", fe);
      check("R10 shift still applied", {31'd0, dout}, {31'd0, fe[10]});
      repeat (3) @(negedge clk);
      le = 1'b0; ci = 1'b0;
      repeat (5) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule